// File: doc/BRIEF.md
# Expansion Bus I/O Slave Window

This block is the card-side responder for a legacy parallel expansion bus. It watches the bus address, the address-enable line and the active-low I/O read and write strobes, all sampled on the bus clock. It claims any I/O cycle that falls inside an eight-byte window at a base chosen from outside the block. Inside that window sit eight byte-wide registers. The block serves reads from them and captures writes into them.

A cycle that falls while address-enable is high belongs to a DMA transfer, so the card ignores it even when the address matches. Read data goes to a data output with a separate output enable. That enable is high only while the card is selected for a read, so the pad ring can build the tri-state driver from it. An internal busy input stands for slow back-end logic. While busy is high and the card is selected, the card pulls the ready line low to ask the bus master for extra clocks. The card makes no attempt to detect another card that decodes the same addresses.

Top module: `io_slave_card`

## Requirements
- R1: The card is selected when address-enable is low, exactly one of the two strobes is low, and bus address bits [9:3] equal the base input.
- R2: While address-enable is high, the card neither drives data nor changes any register, even when the address is inside the window.
- R3: The data output enable is high only while the card is selected with the read strobe low. In that case the data output carries the addressed register. Otherwise the enable is low and the data output is zero.
- R4: A selected write latches the data and the register index. The register is updated on the first clock edge at which the write strobe is sampled high again. Until that edge, a read of the register returns the old value.
- R5: Ready is a registered output. It is low in the cycle after an edge that sampled the card selected with busy high, and high in the cycle after any other edge.
- R6: Changing the base input moves the window. A cycle at an address outside the current window has no effect.
- R7: Synchronous active-high reset clears all eight registers and drives ready high.
- R8: Bus address bits [2:0] select one of eight registers, index 0 at the window base.
- R9: A write whose address is outside the window leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 7 | Window base, compared with address bits [9:3] |
| bus_addr_i | input | 10 | I/O address from the bus |
| aen_i | input | 1 | Address enable; high marks a DMA cycle |
| ior_n_i | input | 1 | I/O read strobe, active low |
| iow_n_i | input | 1 | I/O write strobe, active low |
| data_i | input | 8 | Write data from the bus |
| busy_i | input | 1 | Back-end busy, requests wait states |
| data_o | output | 8 | Read data toward the bus |
| data_oe_o | output | 1 | Output enable for the read data driver |
| ready_o | output | 1 | Bus ready, low to insert wait states |

## Verification
Two functions can meet in one cycle: the trailing edge of a write that commits a register, and a read strobe that falls on the same register at the same time. The bench makes this happen by raising the write strobe and lowering the read strobe on the same falling clock edge. It expects the old value before the next rising edge and the new value after it. It also holds busy high during a selected read. It judges the wait-state request by the registered ready value one clock later, while read data stays on the bus.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

    localparam int ADDR_W_DEF   = 10;
    localparam int WIN_LOG2_DEF = 3;
    localparam int DATA_W_DEF   = 8;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        logic      hit;
        cyc_kind_e kind;
    } dec_t;

    // Both strobes low together is not a legal cycle and is treated as idle.
    function automatic cyc_kind_e classify(input logic ior_n, input logic iow_n);
        cyc_kind_e k;
        unique case ({ior_n, iow_n})
            2'b01:   k = CYC_READ;
            2'b10:   k = CYC_WRITE;
            default: k = CYC_IDLE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/io_window_decode.sv
module io_window_decode
    import isa_io_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int WIN_LOG2 = WIN_LOG2_DEF,
    localparam int BASE_W  = ADDR_W - WIN_LOG2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [BASE_W-1:0]   base_i,
    input  logic                aen_i,
    input  logic                ior_n_i,
    input  logic                iow_n_i,
    output dec_t                dec_o,
    output logic [WIN_LOG2-1:0] idx_o
);

    cyc_kind_e kind;
    logic      in_window;

    always_comb begin
        kind       = classify(ior_n_i, iow_n_i);
        in_window  = (addr_i[ADDR_W-1:WIN_LOG2] == base_i);
        dec_o.kind = kind;
        dec_o.hit  = !aen_i && in_window && (kind != CYC_IDLE);
        idx_o      = addr_i[WIN_LOG2-1:0];
    end

    AST_DMA_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
        aen_i |-> !dec_o.hit); // R2

    AST_HIT_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        dec_o.hit |-> (addr_i[ADDR_W-1:WIN_LOG2] == base_i)); // R6

endmodule

// File: rtl/io_reg_file.sv
module io_reg_file #(
    parameter int DATA_W   = 8,
    parameter int WIN_LOG2 = 3,
    localparam int NREG    = 1 << WIN_LOG2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_hit_i,
    input  logic                iow_n_i,
    input  logic [WIN_LOG2-1:0] idx_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o
);

    logic [DATA_W-1:0]   regs_q [NREG];
    logic                pend_q;
    logic [WIN_LOG2-1:0] pend_idx_q;
    logic [DATA_W-1:0]   pend_data_q;
    logic                commit;

    assign commit = pend_q && iow_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_idx_q  <= '0;
            pend_data_q <= '0;
        end else if (wr_hit_i) begin
            pend_q      <= 1'b1;
            pend_idx_q  <= idx_i;
            pend_data_q <= wdata_i;
        end else if (commit) begin
            pend_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (commit && (pend_idx_q == WIN_LOG2'(g)))
                regs_q[g] <= pend_data_q;
        end

        AST_HELD_WHILE_STROBE: assert property (@(posedge clk) disable iff (rst)
            wr_hit_i |=> $stable(regs_q[g])); // R4
    end

    assign rdata_o = regs_q[idx_i];

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (pend_q && iow_n_i) |=> !pend_q); // R4

endmodule

// File: rtl/io_wait_ctl.sv
module io_wait_ctl (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic busy_i,
    output logic ready_o
);

    always_ff @(posedge clk) begin
        if (rst)
            ready_o <= 1'b1;
        else
            ready_o <= !(hit_i && busy_i);
    end

    AST_WAIT_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
        (hit_i && busy_i) |=> !ready_o); // R5

    AST_RELEASE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        !busy_i |=> ready_o); // R5

endmodule

// File: rtl/io_slave_card.sv
module io_slave_card
    import isa_io_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int WIN_LOG2 = WIN_LOG2_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    localparam int BASE_W  = ADDR_W - WIN_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BASE_W-1:0] base_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              aen_i,
    input  logic              ior_n_i,
    input  logic              iow_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              busy_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              ready_o
);

    dec_t                dec;
    logic [WIN_LOG2-1:0] idx;
    logic [DATA_W-1:0]   rdata;
    logic                wr_hit;

    io_window_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) i_decode (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (bus_addr_i),
        .base_i  (base_i),
        .aen_i   (aen_i),
        .ior_n_i (ior_n_i),
        .iow_n_i (iow_n_i),
        .dec_o   (dec),
        .idx_o   (idx)
    );

    assign wr_hit = dec.hit && (dec.kind == CYC_WRITE);

    io_reg_file #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_hit_i (wr_hit),
        .iow_n_i  (iow_n_i),
        .idx_i    (idx),
        .wdata_i  (data_i),
        .rdata_o  (rdata)
    );

    io_wait_ctl i_wait (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (dec.hit),
        .busy_i  (busy_i),
        .ready_o (ready_o)
    );

    always_comb begin
        data_oe_o = dec.hit && (dec.kind == CYC_READ);
        data_o    = data_oe_o ? rdata : '0;
    end

    AST_NO_DRIVE_ON_DMA: assert property (@(posedge clk) disable iff (rst)
        aen_i |-> !data_oe_o); // R2

    AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> (!ior_n_i && iow_n_i)); // R3

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !data_oe_o |-> (data_o == '0)); // R3

endmodule

// File: tb/test_io_slave_card.sv
module test_io_slave_card;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] base_i = 7'h60;
    logic [9:0] bus_addr_i = '0;
    logic       aen_i = 1'b0;
    logic       ior_n_i = 1'b1;
    logic       iow_n_i = 1'b1;
    logic [7:0] data_i = '0;
    logic       busy_i = 1'b0;
    logic [7:0] data_o;
    logic       data_oe_o;
    logic       ready_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    io_slave_card i_io_slave_card (
        .clk        (clk),
        .rst        (rst),
        .base_i     (base_i),
        .bus_addr_i (bus_addr_i),
        .aen_i      (aen_i),
        .ior_n_i    (ior_n_i),
        .iow_n_i    (iow_n_i),
        .data_i     (data_i),
        .busy_i     (busy_i),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .ready_o    (ready_o)
    );

    // Fields: {write, addr[9:0], aen, wdata[7:0], exp_oe, exp_data[7:0]}
    localparam int NV = 12;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 10'h302, 1'b0, 8'hA5, 1'b0, 8'h00}, // R1 write reg 2
        {1'b0, 10'h302, 1'b0, 8'h00, 1'b1, 8'hA5}, // R1 R3 read back
        {1'b1, 10'h305, 1'b1, 8'h3C, 1'b0, 8'h00}, // R2 DMA write ignored
        {1'b0, 10'h305, 1'b0, 8'h00, 1'b1, 8'h00}, // R2 reg 5 untouched
        {1'b0, 10'h302, 1'b1, 8'h00, 1'b0, 8'h00}, // R2 DMA read not driven
        {1'b1, 10'h30A, 1'b0, 8'h77, 1'b0, 8'h00}, // R9 outside window
        {1'b0, 10'h302, 1'b0, 8'h00, 1'b1, 8'hA5}, // R9 reg 2 unchanged
        {1'b1, 10'h307, 1'b0, 8'h81, 1'b0, 8'h00}, // R8 top index
        {1'b0, 10'h307, 1'b0, 8'h00, 1'b1, 8'h81}, // R8
        {1'b0, 10'h300, 1'b0, 8'h00, 1'b1, 8'h00}, // R8 index 0 separate
        {1'b1, 10'h300, 1'b0, 8'h5A, 1'b0, 8'h00}, // R8
        {1'b0, 10'h300, 1'b0, 8'h00, 1'b1, 8'h5A}  // R8 R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic dma, input logic [7:0] d);
        @(negedge clk);
        bus_addr_i = a; aen_i = dma; data_i = d; iow_n_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        iow_n_i = 1'b1;
        @(negedge clk);
        aen_i = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [9:0] a, input logic dma,
                           input logic exp_oe, input logic [7:0] exp_d);
        @(negedge clk);
        bus_addr_i = a; aen_i = dma; ior_n_i = 1'b0;
        @(negedge clk);
        chk({req, " oe"}, 32'(data_oe_o), 32'(exp_oe));
        chk({req, " data"}, 32'(data_o), 32'(exp_d));
        ior_n_i = 1'b1; aen_i = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 ready in reset", 32'(ready_o), 32'd1);
        chk("R7 oe in reset", 32'(data_oe_o), 32'd0);
        rst = 1'b0;
        do_read("R7 cleared reg", 10'h301, 1'b0, 1'b1, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            if (v[28])
                do_write(v[27:18], v[17], v[16:9]);
            else
                do_read("R3 table", v[27:18], v[17], v[8], v[7:0]);
        end

        // R5: wait request while selected and busy, release after busy clears
        @(negedge clk);
        bus_addr_i = 10'h301; busy_i = 1'b1; ior_n_i = 1'b0;
        @(negedge clk);
        chk("R5 ready low on busy", 32'(ready_o), 32'd0);
        busy_i = 1'b0;
        @(negedge clk);
        chk("R5 ready released", 32'(ready_o), 32'd1);
        bus_addr_i = 10'h3F0; busy_i = 1'b1;
        @(negedge clk);
        chk("R5 no wait when not selected", 32'(ready_o), 32'd1);
        bus_addr_i = 10'h301; aen_i = 1'b1;
        @(negedge clk);
        chk("R2 no wait on DMA cycle", 32'(ready_o), 32'd1);
        ior_n_i = 1'b1; aen_i = 1'b0; busy_i = 1'b0;

        // R6: move the window up by one block
        base_i = 7'h61;
        do_write(10'h30A, 1'b0, 8'h77);
        do_read("R6 new window", 10'h30A, 1'b0, 1'b1, 8'h77);
        do_read("R6 old window off", 10'h302, 1'b0, 1'b0, 8'h00);
        base_i = 7'h60;
        do_read("R6 R8 shared index 2", 10'h302, 1'b0, 1'b1, 8'h77);

        // R4: write commit and read of the same register in one cycle
        do_write(10'h304, 1'b0, 8'h11);
        @(negedge clk);
        bus_addr_i = 10'h304; data_i = 8'h99; iow_n_i = 1'b0; busy_i = 1'b1;
        @(negedge clk);
        iow_n_i = 1'b1; ior_n_i = 1'b0;
        #2;
        chk("R4 old value before commit", 32'(data_o), 32'h11);
        chk("R5 wait during write", 32'(ready_o), 32'd0);
        @(negedge clk);
        chk("R4 new value after commit", 32'(data_o), 32'h99);
        ior_n_i = 1'b1; busy_i = 1'b0;

        // R7: reset in the middle of use clears the bank
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R7 ready after reset", 32'(ready_o), 32'd1);
        do_read("R7 reg 7 cleared", 10'h307, 1'b0, 1'b1, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule